// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter with Underrun Repeat

This block turns a stream of audio data words into a single MSB-first serial bit stream, together with a frame marker for the receiving codec. Each bit period is one pulse of a bit-tick enable, `bit_en`, that is generated outside the block. Words come from a memory-side queue through a valid/ready handshake. The block offers `in_ready` only on the tick that ends the current word, so no bit is ever dropped or cut short.

The block has two formats. In single format each input word holds one 16-bit sample in its low half, and left and right samples alternate. In paired format each input word holds a full stereo pair: left in the low half, right in the high half. Sending the word MSB-first would therefore put right before left. An optional halfword swap reverses the halves so that left goes out first.

If no word is waiting at a word boundary, the block sends its last word again and sets a sticky underrun flag. In paired format the repeat covers both channels, so left/right alignment survives. In single format only one sample is repeated, so every later sample moves by one slot and the channels can end up swapped. The frame marker exposes this.

Top module: `stereo_tx_ser`

## Requirements
- R1: After reset, and until the first word is accepted, `sdata`, `fsync` and `uflow` stay 0. During that time `in_ready` is offered on every cycle in which `bit_en` is 1.
- R2: `in_ready` is 1 only in a cycle with `bit_en` = 1. Once started, it is 1 exactly on the tick that sends the last bit of the current word. A word is 16 ticks long with `mode_pair` = 0 and 32 ticks long with `mode_pair` = 1.
- R3: With `mode_pair` = 0, an accepted word's bits 15..0 are sent on `sdata` starting with bit 15, one bit per tick, beginning in the cycle after acceptance. Bits 31..16 are ignored.
- R4: With `mode_pair` = 1 and `swap_en` = 0, bits 31..0 are sent in that order. The right sample (high half) therefore goes out first.
- R5: With `mode_pair` = 1 and `swap_en` = 1, bits 15..0 are sent first and then bits 31..16, so the left sample goes out first.
- R6: With `mode_pair` = 1, a boundary with `in_valid` low resends the whole previous 32-bit word in the same bit order.
- R7: With `mode_pair` = 0, a boundary with `in_valid` low resends only the previous 16-bit sample.
- R8: `uflow` goes to 1 in the cycle after a boundary with `in_valid` low, once a first word has been accepted. It then holds until a cycle with `uflow_clr` = 1, after which it reads 0. If a set and a clear fall in the same cycle, the set wins.
- R9: `fsync` is 1 during the bit period just before the start of a left slot, and 0 otherwise. Bit positions are counted from 0, where bit 0 is the first bit sent of a word. In paired format with swap, that bit period is the word's last bit (position 31). In paired format without swap, it is position 15. In single format, slots are numbered from 0 at the first accepted sample, and repeated slots are counted too. There, `fsync` is 1 at position 15 of each odd-numbered slot.
- R10: In a cycle with `bit_en` = 0, `sdata` and `fsync` do not change and no word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle pulse per serial bit period |
| mode_pair | input | 1 | 0: one sample per word; 1: packed stereo pair per word |
| swap_en | input | 1 | Send the low halfword first in paired format |
| in_data | input | 32 | Data word from the memory-side queue |
| in_valid | input | 1 | `in_data` holds a word |
| in_ready | output | 1 | The word is taken in this cycle if valid |
| uflow_clr | input | 1 | Pulse that clears the underrun flag |
| sdata | output | 1 | Serial data, MSB first |
| fsync | output | 1 | Marks the bit period before each left slot |
| uflow | output | 1 | Sticky underrun flag |

## Verification
The checker watches the handshake and flag protocol on every cycle. It checks silence before the first word, word-length spacing of `in_ready`, the set, hold and clear of the underrun flag, frozen outputs while `bit_en` is low, and the frame marker on paired-swap boundaries. Bit order, the halfword swap, and the different repeat granularity of the two formats can only be seen by the bench. The bench compares the serial stream bit by bit against words it builds itself, in sweeps over format, swap, underrun patterns and irregular bit ticks. The single-format slip of `fsync` after a one-sample repeat is also shown only by those scenarios.

// File: rtl/stx_pkg.sv
package stx_pkg;
   typedef enum logic {FMT_SINGLE = 1'b0, FMT_PAIR = 1'b1} fmt_e;
   typedef enum logic [1:0] {
      ACT_IDLE   = 2'd0,
      ACT_SHIFT  = 2'd1,
      ACT_LOAD   = 2'd2,
      ACT_REPEAT = 2'd3
   } act_e;
endpackage

// File: rtl/stx_loader.sv
module stx_loader
   import stx_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter bit HAS_SWAP = 1'b1,
   localparam int WORD_W  = 2 * SAMPLE_W
) (
   input  logic [WORD_W-1:0] word_in,
   input  fmt_e              fmt,
   input  logic              swap_req,
   output logic              swap_eff,
   output logic [WORD_W-1:0] word_out
);
   logic [SAMPLE_W-1:0] lo_half, hi_half;
   assign lo_half = word_in[SAMPLE_W-1:0];
   assign hi_half = word_in[WORD_W-1:SAMPLE_W];

   generate
      if (HAS_SWAP) begin : g_swap
         assign swap_eff = swap_req;
      end else begin : g_noswap
         logic unused_swap;
         assign unused_swap = swap_req;
         assign swap_eff    = 1'b0;
      end
   endgenerate

   always_comb begin
      if (fmt == FMT_PAIR)
         word_out = swap_eff ? {lo_half, hi_half} : word_in;
      else
         word_out = {lo_half, {SAMPLE_W{1'b0}}};
   end
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
   import stx_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  act_e              act,
   input  logic [WORD_W-1:0] load_word,
   output logic              started,
   output logic              msb
);
   logic [WORD_W-1:0] shreg, held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         held    <= '0;
         started <= 1'b0;
      end else begin
         case (act)
            ACT_LOAD: begin
               shreg   <= load_word;
               held    <= load_word;
               started <= 1'b1;
            end
            ACT_REPEAT: shreg <= held;
            ACT_SHIFT:  shreg <= {shreg[WORD_W-2:0], 1'b0};
            default:    shreg <= shreg;
         endcase
      end
   end

   assign msb = started & shreg[WORD_W-1];
endmodule

// File: rtl/stx_bitctr.sv
module stx_bitctr
   import stx_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   localparam int WORD_W  = 2 * SAMPLE_W,
   localparam int CNT_W   = $clog2(WORD_W)
) (
   input  logic clk,
   input  logic rst_n,
   input  act_e act,
   input  fmt_e fmt,
   input  logic swap_eff,
   input  logic started,
   output logic last,
   output logic fsync
);
   localparam logic [CNT_W-1:0] LAST_PAIR   = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] LAST_SINGLE = CNT_W'(SAMPLE_W - 1);

   logic [CNT_W-1:0] pos;
   logic             odd_slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos      <= '0;
         odd_slot <= 1'b0;
      end else begin
         case (act)
            ACT_LOAD, ACT_REPEAT: begin
               pos      <= '0;
               odd_slot <= started ? ~odd_slot : 1'b0;
            end
            ACT_SHIFT: pos <= pos + 1'b1;
            default:   pos <= pos;
         endcase
      end
   end

   assign last = (fmt == FMT_PAIR) ? (pos == LAST_PAIR) : (pos == LAST_SINGLE);

   always_comb begin
      if (!started)
         fsync = 1'b0;
      else if (fmt == FMT_PAIR)
         fsync = swap_eff ? (pos == LAST_PAIR) : (pos == LAST_SINGLE);
      else
         fsync = (pos == LAST_SINGLE) && odd_slot;
   end
endmodule

// File: rtl/stereo_tx_ser.sv
module stereo_tx_ser
   import stx_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter bit HAS_SWAP = 1'b1,
   localparam int WORD_W  = 2 * SAMPLE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              mode_pair,
   input  logic              swap_en,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              uflow_clr,
   output logic              sdata,
   output logic              fsync,
   output logic              uflow
);
   generate
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("stereo_tx_ser: SAMPLE_W must be at least 2");
      end
   endgenerate

   fmt_e              fmt;
   act_e              act;
   logic              started, last, boundary, swap_eff;
   logic [WORD_W-1:0] load_word;

   assign fmt = fmt_e'(mode_pair);

   stx_loader #(.SAMPLE_W(SAMPLE_W), .HAS_SWAP(HAS_SWAP)) u_loader (
      .word_in (in_data),
      .fmt     (fmt),
      .swap_req(swap_en),
      .swap_eff(swap_eff),
      .word_out(load_word)
   );

   assign boundary = bit_en && (!started || last);
   assign in_ready = boundary;

   always_comb begin
      if (boundary)
         act = in_valid ? ACT_LOAD : (started ? ACT_REPEAT : ACT_IDLE);
      else if (bit_en && started)
         act = ACT_SHIFT;
      else
         act = ACT_IDLE;
   end

   stx_shifter #(.WORD_W(WORD_W)) u_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act),
      .load_word(load_word),
      .started  (started),
      .msb      (sdata)
   );

   stx_bitctr #(.SAMPLE_W(SAMPLE_W)) u_bitctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (act),
      .fmt     (fmt),
      .swap_eff(swap_eff),
      .started (started),
      .last    (last),
      .fsync   (fsync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         uflow <= 1'b0;
      else if (act == ACT_REPEAT)
         uflow <= 1'b1;
      else if (uflow_clr)
         uflow <= 1'b0;
   end
endmodule

// File: rtl/stx_checker.sv
module stx_checker #(
   parameter int SAMPLE_W = 16,
   localparam int WORD_W  = 2 * SAMPLE_W,
   localparam int CNT_W   = $clog2(WORD_W) + 1
) (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic mode_pair,
   input logic swap_en,
   input logic in_valid,
   input logic in_ready,
   input logic uflow_clr,
   input logic sdata,
   input logic fsync,
   input logic uflow
);
   logic             seen;
   logic [CNT_W-1:0] ticks;
   logic [CNT_W-1:0] word_last;

   assign word_last = mode_pair ? CNT_W'(WORD_W - 1) : CNT_W'(SAMPLE_W - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen  <= 1'b0;
         ticks <= '0;
      end else begin
         if (in_valid && in_ready) seen <= 1'b1;
         if (in_ready && (seen || in_valid))
            ticks <= '0;
         else if (bit_en && seen)
            ticks <= ticks + 1'b1;
      end
   end

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> (!sdata && !fsync && !uflow)); // R1
   AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> bit_en); // R2
   AST_READY_AT_WORD_END: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && in_ready) |-> (ticks == word_last)); // R2
   AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && bit_en && ticks == word_last) |-> in_ready); // R2
   AST_UFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && in_ready && !in_valid) |=> uflow); // R8
   AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow && !uflow_clr) |=> uflow); // R8
   AST_UFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow_clr && !(seen && in_ready && !in_valid)) |=> !uflow); // R8
   AST_UFLOW_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!uflow && !(seen && in_ready && !in_valid)) |=> !uflow); // R8
   AST_FSYNC_PAIR_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && in_ready && mode_pair && swap_en) |-> fsync); // R9
   AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(sdata) && $stable(fsync))); // R10
endmodule

bind stereo_tx_ser stx_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_en   (bit_en),
   .mode_pair(mode_pair),
   .swap_en  (swap_en),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .uflow_clr(uflow_clr),
   .sdata    (sdata),
   .fsync    (fsync),
   .uflow    (uflow)
);

// File: tb/stereo_tx_ser_tb.sv
module stereo_tx_ser_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic        mode_pair = 1'b0;
   logic        swap_en = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        uflow_clr = 1'b0;
   logic        sdata, fsync, uflow;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   stereo_tx_ser u_dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mode_pair(mode_pair),
      .swap_en(swap_en), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .uflow_clr(uflow_clr), .sdata(sdata),
      .fsync(fsync), .uflow(uflow)
   );

   function automatic logic [31:0] mk_word(input int k);
      logic [7:0] b = 8'(k);
      return {b ^ 8'h3C, 8'(k * 7) + 8'h11, b ^ 8'hC5, 8'(k * 13) + 8'h02};
   endfunction

   task automatic check(input string tag, input logic act, input logic exp, input int cyc);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s cycle %0d: got %0b expected %0b", tag, cyc, act, exp);
      end
   endtask

   task automatic run(input bit m, input bit sw, input bit drops, input bit stall,
                      input string tag, input int ncyc);
      logic [31:0] rtx = '0;
      int  rpos = 0, rslot = 0, nb = 0, k = 0;
      bit  rst = 0, rflag = 0;
      int  len = m ? 32 : 16;
      rst_n = 1'b0; bit_en = 1'b0; in_valid = 1'b0; uflow_clr = 1'b0;
      mode_pair = m; swap_en = sw;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1", sdata, 1'b0, 0);
      check("R1", uflow, 1'b0, 0);
      for (int c = 0; c < ncyc; c++) begin
         bit be, v, clr, er, ed, ef, setnow;
         be  = stall ? (c % 3 != 0) : 1'b1;
         v   = (nb >= 3) && !(drops && (nb == 7 || nb == 12 || nb == 13));
         clr = (c == ncyc / 2) || (c == ncyc - 5);
         bit_en = be; in_valid = v; in_data = mk_word(k); uflow_clr = clr;
         #1;
         er = be && (!rst || rpos == len - 1);
         ed = rst ? rtx[len - 1 - rpos] : 1'b0;
         ef = rst && (m ? (sw ? rpos == 31 : rpos == 15) : (rpos == 15 && rslot[0]));
         check(rst ? tag : "R1", sdata, ed, c);
         check("R2", in_ready, er, c);
         check("R9", fsync, ef, c);
         check("R8", uflow, rflag, c);
         @(posedge clk);
         setnow = 0;
         if (er) begin
            nb++;
            if (v) begin
               logic [31:0] d = mk_word(k);
               rtx = m ? (sw ? {d[15:0], d[31:16]} : d) : {16'h0, d[15:0]};
               rslot = rst ? rslot + 1 : 0;
               rst = 1; rpos = 0; k++;
            end else if (rst) begin
               rpos = 0; rslot++; rflag = 1; setnow = 1;
            end
         end else if (be && rst) begin
            rpos++;
         end
         if (clr && !setnow) rflag = 0;
         @(negedge clk);
      end
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int m = 0; m < 2; m++)
         for (int sw = 0; sw < 2; sw++)
            for (int dr = 0; dr < 2; dr++) begin
               string t;
               if (m == 0) t = dr ? "R7" : "R3";
               else        t = dr ? "R6" : (sw ? "R5" : "R4");
               run(m[0], sw[0], dr[0], 1'b0, t, m ? 640 : 340);
            end
      run(1'b1, 1'b1, 1'b1, 1'b1, "R10", 1000);
      run(1'b0, 1'b0, 1'b1, 1'b1, "R10", 600);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule